// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a windowed register file for a processor core. Software always addresses 32 logical registers through a 5-bit index. Logical registers 0 to 9 are globals that every procedure shares. Registers 10 to 15 are the procedure's incoming parameters, 16 to 25 are its private locals, and 26 to 31 are its outgoing parameters. A 3-bit window pointer selects which slice of the physical store backs the windowed registers.

A call strobe moves the pointer down by one window and a return strobe moves it up by one. The window pointer wraps modulo 8. After a call, the six outgoing registers of the caller are the same physical registers as the six incoming registers of the callee, so parameters and results pass without any copying. Each window owns ten locals and six shared slots. The store therefore holds 10 + 8 x 16 = 138 registers.

A call depth counter guards the ring. A call that would put an eighth window into use is refused and raises an overflow flag. A return at depth zero raises an underflow flag. In both cases the pointer stays where it is. Spilling windows to memory is left to whatever handles those flags.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer is 0, the depth is 0, both flags are low and every logical register reads as 0.
- R2: Logical register 0 always reads 0, and a write to it leaves every register unchanged.
- R3: An accepted call (call_i high, ret_i low) decrements the window pointer modulo 8 at the clock edge. A write in the same cycle lands in the window that was current before that edge.
- R4: An accepted return (ret_i high, call_i low) increments the window pointer modulo 8 at the clock edge.
- R5: After a call, the callee's logical register 10+k (k = 0..5) holds the value the caller wrote to its logical register 26+k, and the reverse holds after a return.
- R6: A call made while 7 windows are in use (depth 6) leaves the pointer and depth unchanged and drives ovf_o high for exactly the following cycle.
- R7: A return made at depth 0 leaves the pointer unchanged and drives unf_o high for exactly the following cycle.
- R8: Locals (16..25) and incoming registers of a callee are physically distinct from the caller's locals. Writes made by the callee do not change what the caller reads from them after returning.
- R9: Logical registers 1..9 are the same physical registers in every window.
- R10: Reads are combinational. When a write in the same cycle targets the physical register being read, the read port shows the write data.
- R11: When call_i and ret_i are high together, the window pointer, the depth and both flags behave as if neither were asserted.
- R12: Window addressing wraps. A call from pointer 0 selects pointer 7, and the outgoing registers of window 0 share storage with the incoming registers of window 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_addr | input | 5 | Logical index for read port A |
| rd_b_addr | input | 5 | Logical index for read port B |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical index written |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | One-cycle pulse: refused call |
| unf_o | output | 1 | One-cycle pulse: refused return |

## Verification
The bench checks that outgoing values reappear as incoming values after a call. If the outgoing slot were tied to the wrong neighbouring window, the callee would read stale data from an unrelated window. The bench also exercises the wrap from pointer 0 to 7, where a mapping that is not taken modulo the ring would reach past the store or alias a global. It drives the depth exactly to the refusal points, where an off-by-one limit either lets a call clobber the root window's incoming registers or refuses a legal call. Writes coinciding with a call and with a read of the same register test forwarding and the pre-edge window choice: a design that got those wrong would return old data or store the value one window away.

// File: rtl/rwin_pkg.sv
// Shared constants and helpers for the windowed register file.
// Assumes a fixed 32-entry logical view split into four groups.
package rwin_pkg;

    localparam int LREG_W   = 5;
    localparam int NUM_GLB  = 10;
    localparam int IN_BASE  = 10;
    localparam int LOC_BASE = 16;
    localparam int OUT_BASE = 26;
    localparam int NUM_IO   = 6;
    localparam int NUM_LOC  = 10;
    localparam int WIN_SPAN = NUM_IO + NUM_LOC;

    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_IN  = 2'd1,
        GRP_LOC = 2'd2,
        GRP_OUT = 2'd3
    } grp_e;

    // Classify a logical index into its register group.
    function automatic grp_e grp_of(input logic [LREG_W-1:0] a);
        if (a < LREG_W'(IN_BASE))       return GRP_GLB;
        else if (a < LREG_W'(LOC_BASE)) return GRP_IN;
        else if (a < LREG_W'(OUT_BASE)) return GRP_LOC;
        else                            return GRP_OUT;
    endfunction

endpackage

// File: rtl/rwin_map.sv
// Maps one logical register index to a physical store index under the
// current window pointer. Globals map to themselves. Incoming and local
// registers use the current window's slot block. Outgoing registers use
// the first slots of the next lower window, modulo the ring.
// Assumes NWIN is a power of two so the ring wrap is a plain truncation.
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWP_W  = $clog2(NWIN),
    localparam int SLOT_W = $clog2(WIN_SPAN),
    localparam int NPHYS  = NUM_GLB + NWIN * WIN_SPAN,
    localparam int PIDX_W = $clog2(NPHYS)
) (
    input  logic [LREG_W-1:0] laddr,
    input  logic [CWP_W-1:0]  cwp,
    output logic [PIDX_W-1:0] pidx
);

    grp_e              grp;
    logic [CWP_W-1:0]  win_sel;
    logic [SLOT_W-1:0] slot;

    // Select the window and the slot within it for the addressed group.
    always_comb begin
        grp     = grp_of(laddr);
        win_sel = cwp;
        slot    = '0;
        unique case (grp)
            GRP_IN, GRP_LOC: slot = SLOT_W'(laddr - LREG_W'(IN_BASE));
            GRP_OUT: begin
                win_sel = cwp - CWP_W'(1);
                slot    = SLOT_W'(laddr - LREG_W'(OUT_BASE));
            end
            default: slot = '0;
        endcase
    end

    // Form the physical index; the windowed area sits above the globals.
    always_comb begin
        if (grp == GRP_GLB)
            pidx = PIDX_W'(laddr);
        else
            pidx = PIDX_W'(NUM_GLB) + PIDX_W'({win_sel, slot});
    end

endmodule

// File: rtl/rwin_ctrl.sv
// Window pointer and call-depth tracking. An accepted call moves the
// pointer down one window, an accepted return moves it up. A refused
// call or return leaves state alone and pulses a flag for one cycle.
// Assumes NWIN >= 4; the depth limit keeps one window free so the
// deepest callee's outgoing registers never alias the root's incoming ones.
module rwin_ctrl #(
    parameter int NWIN = 8,
    localparam int CWP_W = $clog2(NWIN),
    localparam int MAXD  = NWIN - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [CWP_W-1:0] cwp,
    output logic [CWP_W-1:0] depth,
    output logic             ovf,
    output logic             unf
);

    logic do_call;
    logic do_ret;
    logic at_top;
    logic at_root;

    // Decode the strobes; both together cancel out.
    always_comb begin
        do_call = call_i && !ret_i;
        do_ret  = ret_i && !call_i;
        at_top  = (depth == CWP_W'(MAXD));
        at_root = (depth == '0);
    end

    // Advance the pointer and depth, or raise a refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp   <= '0;
            depth <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            unf <= 1'b0;
            if (do_call) begin
                if (at_top) begin
                    ovf <= 1'b1;
                end else begin
                    cwp   <= cwp - CWP_W'(1);
                    depth <= depth + CWP_W'(1);
                end
            end else if (do_ret) begin
                if (at_root) begin
                    unf <= 1'b1;
                end else begin
                    cwp   <= cwp + CWP_W'(1);
                    depth <= depth - CWP_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rwin_store.sv
// Physical register storage with one write port and NRD combinational
// read ports. Physical index 0 is the hard-wired zero register: it reads
// as zero and ignores writes. A same-cycle write to the index being read
// is forwarded to that read port.
// Assumes the physical indices come from rwin_map and are below NPHYS.
module rwin_store #(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 138,
    parameter int NRD    = 2,
    localparam int PIDX_W = $clog2(NPHYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PIDX_W-1:0]            wr_pidx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NRD-1:0][PIDX_W-1:0]   rd_pidx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data
);

    logic [DATA_W-1:0] regs [NPHYS];
    logic              wr_live;

    // A write is live unless it targets the zero register.
    always_comb wr_live = wr_en && (wr_pidx != '0);

    // Clear the store on reset, otherwise commit the live write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[wr_pidx] <= wr_data;
        end
    end

    // Build each read port with zero and forwarding handling.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_pidx[p] == '0)
                rd_data[p] = '0;
            else if (wr_live && (wr_pidx == rd_pidx[p]))
                rd_data[p] = wr_data;
            else
                rd_data[p] = regs[rd_pidx[p]];
        end
    end

endmodule

// File: rtl/rwin_file.sv
// Overlapped register window file: two read ports and one write port
// addressed by 5-bit logical indices, with call/return strobes moving a
// circular window pointer. Instantiates one address mapper per port,
// the pointer controller and the physical store.
// Assumes the reads and the write in a cycle all use the pointer value
// held before that cycle's clock edge.
module rwin_file
    import rwin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWIN   = 8,
    localparam int CWP_W  = $clog2(NWIN),
    localparam int NPHYS  = NUM_GLB + NWIN * WIN_SPAN,
    localparam int PIDX_W = $clog2(NPHYS),
    localparam int NRD    = 2,
    localparam int NPORT  = NRD + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_a_addr,
    input  logic [4:0]        rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_i,
    input  logic              ret_i,
    output logic [2:0]        cwp_o,
    output logic              ovf_o,
    output logic              unf_o
);

    logic [CWP_W-1:0]                 cwp;
    logic [CWP_W-1:0]                 win_depth;
    logic [NPORT-1:0][LREG_W-1:0]     port_laddr;
    logic [NPORT-1:0][PIDX_W-1:0]     port_pidx;
    logic [NRD-1:0][PIDX_W-1:0]       rd_pidx;
    logic [NRD-1:0][DATA_W-1:0]       rd_data;

    // Gather logical indices: port 0 writes, the rest read.
    always_comb begin
        port_laddr[0] = wr_addr;
        port_laddr[1] = rd_a_addr;
        port_laddr[2] = rd_b_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(.NWIN(NWIN)) u_map (
            .laddr (port_laddr[p]),
            .cwp   (cwp),
            .pidx  (port_pidx[p])
        );
    end

    // Route the read-side physical indices to the store.
    for (genvar p = 0; p < NRD; p++) begin : g_rdsel
        assign rd_pidx[p] = port_pidx[p+1];
    end

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp    (cwp),
        .depth  (win_depth),
        .ovf    (ovf_o),
        .unf    (unf_o)
    );

    rwin_store #(.DATA_W(DATA_W), .NPHYS(NPHYS), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_pidx (port_pidx[0]),
        .wr_data (wr_data),
        .rd_pidx (rd_pidx),
        .rd_data (rd_data)
    );

    // Drive the output ports.
    always_comb begin
        rd_a_data = rd_data[0];
        rd_b_data = rd_data[1];
        cwp_o     = 3'(cwp);
    end

endmodule

// File: rtl/rwin_chk.sv
// Temporal checks on the window pointer, the refusal flags and the zero
// register. Bound into rwin_file; it only observes.
module rwin_chk #(
    parameter int DATA_W = 32,
    parameter int NWIN   = 8,
    localparam int CWP_W = $clog2(NWIN),
    localparam int MAXD  = NWIN - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic              ret_i,
    input logic [CWP_W-1:0]  cwp,
    input logic [CWP_W-1:0]  depth,
    input logic              ovf,
    input logic              unf,
    input logic [4:0]        rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data
);

    p_call_moves_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && depth != CWP_W'(MAXD)) |=> (cwp == CWP_W'($past(cwp) - CWP_W'(1))));

    p_ret_moves_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && depth != '0) |=> (cwp == CWP_W'($past(cwp) + CWP_W'(1))));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && depth == CWP_W'(MAXD)) |=> (ovf && $stable(cwp)));

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && depth == '0) |=> (unf && $stable(cwp)));

    p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

    p_both_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> (!ovf && !unf && $stable(cwp) && $stable(depth)));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

endmodule

bind rwin_file rwin_chk #(.DATA_W(DATA_W), .NWIN(NWIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .cwp       (cwp),
    .depth     (win_depth),
    .ovf       (ovf_o),
    .unf       (unf_o),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data)
);

// File: tb/sim_rwin_file.sv
// Bench for rwin_file: a behavioural model (flat integer store, integer
// pointer and depth) compared against the ports on every clock.
module sim_rwin_file;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, call_i, ret_i;
    logic [2:0]  cwp_o;
    logic        ovf_o, unf_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // model state
    logic [31:0] m_mem [138];
    int m_cwp, m_depth;
    logic m_ovf, m_unf;
    // last observed outputs
    logic [31:0] obs_a, obs_b;
    int obs_cwp;
    logic obs_ovf, obs_unf;

    always #(PERIOD/2) clk = ~clk;

    rwin_file u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic int phys(input int a, input int w);
        if (a < 10) return a;
        if (a < 26) return 10 + ((w * 16 + a - 10) % 128);
        return 10 + ((((w + 7) % 8) * 16 + a - 26) % 128);
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a == 0) return 32'd0;
        if (wr_en && wr_addr != 0 && phys(int'(wr_addr), m_cwp) == phys(a, m_cwp))
            return wr_data;
        return m_mem[phys(a, m_cwp)];
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: drive, compare against model, advance the model.
    task automatic cyc(input logic we, input int wa, input logic [31:0] wd,
                       input int ra, input int rb, input logic c, input logic r);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        rd_a_addr = 5'(ra); rd_b_addr = 5'(rb); call_i = c; ret_i = r;
        #2;
        obs_a = rd_a_data; obs_b = rd_b_data; obs_cwp = int'(cwp_o);
        obs_ovf = ovf_o; obs_unf = unf_o;
        chk(cur_req, "rd_a", obs_a, m_read(ra));
        chk(cur_req, "rd_b", obs_b, m_read(rb));
        chk(cur_req, "cwp", obs_cwp, m_cwp);
        chk(cur_req, "ovf", obs_ovf, m_ovf);
        chk(cur_req, "unf", obs_unf, m_unf);
        @(posedge clk);
        if (we && wa != 0) m_mem[phys(wa, m_cwp)] = wd;
        m_ovf = 1'b0; m_unf = 1'b0;
        if (c && !r) begin
            if (m_depth == 6) m_ovf = 1'b1;
            else begin m_cwp = (m_cwp + 7) % 8; m_depth++; end
        end else if (r && !c) begin
            if (m_depth == 0) m_unf = 1'b1;
            else begin m_cwp = (m_cwp + 1) % 8; m_depth--; end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 138; i++) m_mem[i] = 32'd0;
        m_cwp = 0; m_depth = 0; m_ovf = 0; m_unf = 0;
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
        rd_a_addr = 0; rd_b_addr = 0; call_i = 0; ret_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all registers zero
        cur_req = "R1";
        for (int i = 0; i < 32; i += 2) cyc(0, 0, 0, i, i + 1, 0, 0);
        chk("R1", "cwp after reset", obs_cwp, 0);

        // R2: writes to register 0 are dropped
        cur_req = "R2";
        cyc(1, 0, 32'hFFFF_FFFF, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R2", "r0 after write", obs_a, 0);

        // R10 and R9: forwarding, globals written
        cur_req = "R10";
        for (int g = 1; g < 10; g++) cyc(1, g, 32'hA000 + g, g, 0, 0, 0);
        cyc(1, 20, 32'h1234_5678, 20, 20, 0, 0);
        chk("R10", "forwarded read", obs_a, 32'h1234_5678);

        // R5/R3: fill outs and caller locals, call, read ins
        cur_req = "R5";
        for (int k = 0; k < 6; k++) cyc(1, 26 + k, 32'hB000 + k, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) cyc(1, 16 + k, 32'hC000 + k, 0, 0, 0, 0);
        cur_req = "R3";
        cyc(1, 17, 32'hC0DE, 0, 0, 1, 0); // write in same cycle uses old window
        cur_req = "R12";
        cyc(0, 0, 0, 10, 15, 0, 0);
        chk("R12", "cwp wraps to 7", obs_cwp, 7);
        chk("R5", "callee in r10", obs_a, 32'hB000);
        chk("R5", "callee in r15", obs_b, 32'hB005);
        cur_req = "R9";
        cyc(0, 0, 0, 3, 9, 0, 0);
        chk("R9", "global r3 in callee", obs_a, 32'hA003);

        // R8: callee scribbles its locals and ins, returns
        cur_req = "R8";
        for (int k = 10; k < 26; k++) cyc(1, k, 32'hD000 + k, 0, 0, 0, 0);
        cur_req = "R4";
        cyc(0, 0, 0, 0, 0, 0, 1);
        cur_req = "R8";
        cyc(0, 0, 0, 16, 17, 0, 0);
        chk("R8", "caller local r16", obs_a, 32'hC000);
        chk("R8", "caller local r17", obs_b, 32'hC0DE);
        cyc(0, 0, 0, 26, 31, 0, 0);
        chk("R5", "result back in out r26", obs_a, 32'hD00A);
        chk("R4", "cwp back to 0", obs_cwp, 0);

        // R6: six calls accepted, seventh refused
        cur_req = "R6";
        for (int d = 0; d < 6; d++) cyc(0, 0, 0, 10, 26, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6", "ovf pulse", obs_ovf, 1);
        chk("R6", "cwp held", obs_cwp, 2);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6", "ovf one cycle", obs_ovf, 0);

        // R11: both strobes together
        cur_req = "R11";
        cyc(0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R11", "cwp unchanged", obs_cwp, 2);

        // R7: unwind then one extra return
        cur_req = "R7";
        for (int d = 0; d < 6; d++) cyc(0, 0, 0, 11, 27, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R7", "unf pulse", obs_unf, 1);
        chk("R7", "cwp held", obs_cwp, 0);

        // mixed traffic
        cur_req = "R5";
        for (int n = 0; n < 2000; n++) begin
            int sel = int'($urandom_range(0, 15));
            cyc(logic'($urandom_range(0, 1)), int'($urandom_range(0, 31)), $urandom(),
                int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                sel < 3, sel == 3 || sel == 4 || sel == 15);
        end

        summary();
        $finish;
    end

endmodule